// File: doc/BRIEF.md
# Associative Page-Frame Translator

This block translates an effective word address into a physical address by searching a small table held per physical page frame. Every frame owns one register holding the virtual page that currently lives in it, a present flag and a usage flag. A lookup splits the address into a page number and a word offset, compares the page number against all frame registers at once and, on a match, uses the position of the matching register as the physical frame number. The frame number is never stored as a field.

When no register matches, the block reports a page fault. In the same response it names the frame the fault handler should fill. If a frame is free, it names the lowest free one. If not, it names a victim chosen from the usage flags and marks it for write-back. The handler then loads the chosen frame through a write port. Lookups use a valid/ready handshake, and the result appears one clock after acceptance.

Top module: `frame_match_xlate`

## Requirements
- R1: After reset no frame is present, every usage flag is clear, `rsp_valid` is 0 and `req_ready` is 1. The first lookup therefore faults and names frame 0 with `rsp_wb` = 0.
- R2: A lookup whose page matches a present frame returns `rsp_hit`=1, `rsp_fault`=0, `rsp_frame` set to the matching frame index, and `rsp_paddr` = {frame index, offset}.
- R3: A lookup that matches no present frame returns `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R4: The low 9 bits of `req_addr` are the word offset and bits 16:9 are the page number. Page numbers of 192 and above always fault, even when a frame register holds that value.
- R5: A write with `wr_present`=1 loads `wr_page` into frame `wr_frame` and marks it present. A write with `wr_present`=0 marks the frame absent. `req_ready` is 0 in any cycle where `wr_en` is 1.
- R6: On a fault while at least one frame is absent, `rsp_frame` is the lowest-indexed absent frame and `rsp_wb`=0.
- R7: On a fault with every frame present, `rsp_frame` is the lowest-indexed frame whose usage flag is clear, and `rsp_wb`=1.
- R8: A hit sets the usage flag of the frame it uses. A present-load sets the loaded frame's flag and an absent-write clears it. If an update would leave every flag set, all flags are cleared instead.
- R9: If more than one present frame matches, `rsp_multi`=1 and the lowest-indexed match is used as a hit.
- R10: `rsp_valid` is 1 exactly in the cycle after a request is accepted (`req_valid` and `req_ready` both 1) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_addr | input | 17 | Effective word address: page in [16:9], offset in [8:0] |
| wr_en | input | 1 | Frame register write strobe |
| wr_frame | input | 5 | Frame whose register is written |
| wr_page | input | 8 | Virtual page number to store |
| wr_present | input | 1 | Present flag to store |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup matched a present frame |
| rsp_fault | output | 1 | Lookup matched nothing |
| rsp_multi | output | 1 | More than one frame matched |
| rsp_wb | output | 1 | Named fill frame is occupied and needs write-back |
| rsp_frame | output | 5 | Matching frame on a hit, fill frame on a fault |
| rsp_paddr | output | 14 | Physical word address on a hit, zero on a fault |

## Verification
Lookups are tried against an empty table, a sparse table with gaps, and a fully loaded table. The empty table separates the reset state from normal operation. The sparse table separates a true hit from the choice of the lowest free frame. The full table forces the usage-based victim path and its write-back flag. Walking hits across frames in order shows that usage flags accumulate and then clear together. Duplicate page loads and out-of-range page numbers separate the multi-match priority from the range gate. A write issued alongside a lookup shows that the write wins the cycle and produces no response.

// File: rtl/frame_match_xlate.sv
module frame_match_xlate #(
  parameter int FRAMES = 32,
  parameter int OFF_W  = 9,
  parameter int PAGES  = 192,
  parameter int VPN_W  = $clog2(PAGES),
  parameter int FR_W   = $clog2(FRAMES),
  parameter int VA_W   = VPN_W + OFF_W,
  parameter int PA_W   = FR_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             wr_en,
  input  logic [FR_W-1:0]  wr_frame,
  input  logic [VPN_W-1:0] wr_page,
  input  logic             wr_present,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             rsp_multi,
  output logic             rsp_wb,
  output logic [FR_W-1:0]  rsp_frame,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic [VPN_W-1:0]  page_q [FRAMES];
  logic [FRAMES-1:0] present_q, use_q, match, use_nx;

  wire [VPN_W-1:0] req_page = req_addr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] req_off  = req_addr[OFF_W-1:0];
  wire             in_range = 32'(req_page) < PAGES;
  wire             accept   = req_valid && req_ready;

  assign req_ready = !wr_en;

  for (genvar i = 0; i < FRAMES; i++) begin : g_cmp
    assign match[i] = present_q[i] && in_range && (page_q[i] == req_page);
  end

  function automatic logic [FR_W-1:0] lowest(input logic [FRAMES-1:0] v);
    lowest = '0;
    for (int k = FRAMES - 1; k >= 0; k--)
      if (v[k]) lowest = FR_W'(k);
  endfunction

  wire              any_hit  = |match;
  wire              multi    = |(match & (match - 1'b1));
  wire [FR_W-1:0]   hit_idx  = lowest(match);
  wire              any_free = ~&present_q;
  wire [FR_W-1:0]   free_idx = lowest(~present_q);
  wire [FR_W-1:0]   vict_idx = lowest(~use_q);

  always_comb begin
    use_nx = use_q;
    if (accept && any_hit) use_nx[hit_idx] = 1'b1;
    if (wr_en) use_nx[wr_frame] = wr_present;
    if (&use_nx) use_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present_q <= '0;
      use_q     <= '0;
    end else begin
      use_q <= use_nx;
      if (wr_en) present_q[wr_frame] <= wr_present;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_present) page_q[wr_frame] <= wr_page;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_wb    <= 1'b0;
      rsp_frame <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit   <= any_hit;
        rsp_fault <= !any_hit;
        rsp_multi <= multi;
        rsp_wb    <= !any_hit && !any_free;
        rsp_frame <= any_hit ? hit_idx : (any_free ? free_idx : vict_idx);
        rsp_paddr <= any_hit ? {hit_idx, req_off} : '0;
      end
    end
  end

endmodule

// File: rtl/frame_match_xlate_chk.sv
module frame_match_xlate_chk #(
  parameter int VA_W  = 17,
  parameter int OFF_W = 9,
  parameter int FR_W  = 5,
  parameter int PA_W  = 14,
  parameter int PAGES = 192
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_addr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic            rsp_multi,
  input logic            rsp_wb,
  input logic [FR_W-1:0] rsp_frame,
  input logic [PA_W-1:0] rsp_paddr
);
  wire acc = req_valid && req_ready;

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) acc |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !acc |=> !rsp_valid); // R10
  AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_hit ^ rsp_fault)); // R2
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])); // R2
  AST_HIT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_paddr[PA_W-1:OFF_W] == rsp_frame); // R2
  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_paddr == '0); // R3
  AST_HIGH_PAGE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && 32'(req_addr[VA_W-1:OFF_W]) >= PAGES) |=> rsp_fault); // R4
  AST_WB_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wb) |-> rsp_fault); // R7
  AST_MULTI_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi) |-> rsp_hit); // R9
endmodule

bind frame_match_xlate frame_match_xlate_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .FR_W(FR_W), .PA_W(PA_W), .PAGES(PAGES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_multi(rsp_multi), .rsp_wb(rsp_wb),
  .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr)
);

// File: tb/frame_match_xlate_tb.sv
module frame_match_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_frame = '0;
  logic [7:0]  wr_page = '0;
  logic        wr_present = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_multi, rsp_wb;
  logic [4:0]  rsp_frame;
  logic [13:0] rsp_paddr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_match_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .wr_en(wr_en), .wr_frame(wr_frame), .wr_page(wr_page),
    .wr_present(wr_present), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_multi(rsp_multi), .rsp_wb(rsp_wb),
    .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr)
  );

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int frame, input int page, input bit present);
    @(negedge clk);
    wr_en = 1'b1; wr_frame = 5'(frame); wr_page = 8'(page); wr_present = present;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input int page, input int off);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {8'(page), 9'(off)};
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input int frame, input int off, input bit multi);
    expect_eq({tag, " valid"}, 32'(rsp_valid), 1);
    expect_eq({tag, " hit"}, 32'(rsp_hit), 1);
    expect_eq({tag, " fault"}, 32'(rsp_fault), 0);
    expect_eq({tag, " frame"}, 32'(rsp_frame), 32'(frame));
    expect_eq({tag, " paddr"}, 32'(rsp_paddr), 32'(frame * 512 + off));
    expect_eq({tag, " multi"}, 32'(rsp_multi), 32'(multi));
  endtask

  task automatic expect_fault(input string tag, input int frame, input bit wb);
    expect_eq({tag, " valid"}, 32'(rsp_valid), 1);
    expect_eq({tag, " fault"}, 32'(rsp_fault), 1);
    expect_eq({tag, " hit"}, 32'(rsp_hit), 0);
    expect_eq({tag, " paddr"}, 32'(rsp_paddr), 0);
    expect_eq({tag, " frame"}, 32'(rsp_frame), 32'(frame));
    expect_eq({tag, " wb"}, 32'(rsp_wb), 32'(wb));
  endtask

  task automatic t_reset();
    expect_eq("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    expect_eq("R1 req_ready after reset", 32'(req_ready), 1);
    lookup(3, 5);
    expect_fault("R1 empty table", 0, 0);
    @(negedge clk);
    expect_eq("R10 strobe lasts one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic t_sparse();
    load(0, 5, 1);
    load(2, 7, 1);
    lookup(5, 9'h1AB);
    expect_hit("R2 frame0", 0, 9'h1AB, 0);
    lookup(7, 9'h1FF);
    expect_hit("R2 R4 frame2 max offset", 2, 9'h1FF, 0);
    lookup(8, 0);
    expect_fault("R3 R6 gap frame1", 1, 0);
    load(0, 5, 0);
    lookup(5, 1);
    expect_fault("R5 R6 invalidated frame0", 0, 0);
  endtask

  task automatic t_range();
    load(1, 200, 1);
    lookup(200, 4);
    expect_fault("R4 page above 191", 0, 0);
  endtask

  task automatic t_write_blocks();
    @(negedge clk);
    wr_en = 1'b1; wr_frame = 5'd0; wr_page = 8'd50; wr_present = 1'b1;
    req_valid = 1'b1; req_addr = {8'd50, 9'd3};
    #1;
    expect_eq("R5 ready low during write", 32'(req_ready), 0);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    expect_eq("R10 no response for refused request", 32'(rsp_valid), 0);
    lookup(50, 3);
    expect_hit("R5 written frame0", 0, 3, 0);
  endtask

  task automatic t_multi();
    load(4, 9, 1);
    load(3, 9, 1);
    lookup(9, 17);
    expect_hit("R9 duplicate page", 3, 17, 1);
  endtask

  task automatic t_full();
    for (int f = 0; f < 32; f++) load(f, f + 10, 1);
    lookup(100, 0);
    expect_fault("R7 R8 full, flags cleared by last load", 0, 1);
    for (int f = 0; f < 3; f++) begin
      lookup(f + 10, f);
      expect_hit("R2 full table", f, f, 0);
    end
    lookup(100, 0);
    expect_fault("R7 R8 victim after three hits", 3, 1);
    for (int f = 3; f < 32; f++) lookup(f + 10, 0);
    expect_hit("R8 last frame hit", 31, 0, 0);
    lookup(100, 0);
    expect_fault("R8 all flags wrapped", 0, 1);
    load(6, 0, 0);
    lookup(100, 0);
    expect_fault("R6 one absent frame", 6, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sparse();
    t_range();
    t_write_blocks();
    t_multi();
    t_full();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule